// File: doc/BRIEF.md
# Received Character Window Detector

This block sits beside a serial receiver and inspects every character the receiver delivers. Software programs an inclusive value window: a lower bound and an upper bound, each 16 bits, held together in one 32-bit register. Each time the receiver presents a character, the block tests it against the window. A character inside the window sets a sticky status flag. If partial wakeup is enabled, the same character also produces a one-cycle wakeup request towards the power controller.

The window register is reached over a simple synchronous bus with write, read, address and data signals. A write-protect input freezes the register: while it is high, bus writes to the window are dropped. Reading the status register returns the flag and clears it. A match that arrives in the same cycle as that read wins, so the flag stays set.

Top module: `char_window_detect`

## Requirements
- R1: After reset, both bounds read as zero, the match flag is low and the wakeup request is low.
- R2: With write protection off, a bus write to byte address 0x448 stores bits 15:0 as the lower bound and bits 31:16 as the upper bound. A read of 0x448 returns them in the same positions, in the same cycle as the read strobe.
- R3: With write protection on, a bus write to 0x448 is dropped, and the stored bounds keep their previous value.
- R4: A read of 0x448 returns the stored bounds whether write protection is on or off.
- R5: A character presented with the valid strobe matches when, zero-extended to 16 bits, it is at least the lower bound and at most the upper bound. A match sets the flag at the next clock edge.
- R6: A character presented without the valid strobe is never compared: the flag and the wakeup request stay unchanged.
- R7: The flag is sticky. A read of the status register at byte address 0x414 returns the flag in bit 0, with all other bits zero, and clears the flag at that clock edge.
- R8: If a matching strobe arrives in the same cycle as a status read, the flag is still set after that edge.
- R9: When the lower bound is greater than the upper bound, no character matches: no flag and no wakeup.
- R10: When the wakeup enable input is high, each matching strobe produces a wakeup request that is high for exactly the one cycle after the strobe edge. When the enable is low, the request stays low while the flag still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W (12) | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, valid while bus_rd is high |
| wp_en | input | 1 | Write protection; high blocks window writes |
| wake_en | input | 1 | Partial wakeup enable |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_char | input | CHAR_W (8) | Received character value |
| match_flag | output | 1 | Sticky match flag |
| wake_req | output | 1 | One-cycle wakeup request |

## Verification
The bench uses 8-bit characters and sweeps all 256 values through a set of windows. The set includes a band in the middle of the range, single-value windows at both ends of the range, the full 16-bit range, an inverted window, and a window that lies wholly above 255. The middle band and the single-value windows separate inclusive comparisons from exclusive ones at each edge. The inverted window shows that an empty window stays empty. The window above 255 shows that characters are zero-extended rather than truncated against the bounds. Alternating the wakeup enable between windows separates the flag path from the wakeup path. Directed sequences cover the remaining cases: a character held without its strobe, a status read that coincides with a match, and writes made while protection is on.

// File: rtl/cwd_pkg.sv
// Package: shared widths and the window register layout for the
// character window detector. Upper bound sits in the high half.
package cwd_pkg;
    localparam int BOUND_W = 16;
    localparam int REG_W   = 2 * BOUND_W;

    typedef struct packed {
        logic [BOUND_W-1:0] hi;
        logic [BOUND_W-1:0] lo;
    } win_cfg_t;
endpackage

// File: rtl/cwd_cfg_reg.sv
// Module: window bound register with write-protect gating.
// Assumes single-cycle write strobes and an exact byte address decode.
module cwd_cfg_reg
    import cwd_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CMP_ADDR = 12'h448
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wp_en,
    output win_cfg_t          cfg_q
);
    logic wr_ok;

    // Accept a write only at the window address with protection off.
    always_comb begin
        wr_ok = wr && (addr == CMP_ADDR) && !wp_en;
    end

    // Hold the bounds; load both halves on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_ok) begin
            cfg_q <= win_cfg_t'(wdata);
        end
    end
endmodule

// File: rtl/cwd_window.sv
// Module: inclusive window comparator. Zero-extends the character to
// the bound width. Assumes CHAR_W is not larger than BOUND_W.
module cwd_window
    import cwd_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] char_in,
    input  win_cfg_t          cfg,
    output logic              hit
);
    logic [BOUND_W-1:0] char_ext;

    // Widen the character: pad with zeros only when it is narrower.
    generate
        if (CHAR_W < BOUND_W) begin : g_pad
            assign char_ext = {{(BOUND_W-CHAR_W){1'b0}}, char_in};
        end else begin : g_direct
            assign char_ext = char_in;
        end
    endgenerate

    // Both ends inclusive; an inverted window can never be satisfied.
    always_comb begin
        hit = (char_ext >= cfg.lo) && (char_ext <= cfg.hi);
    end
endmodule

// File: rtl/cwd_status.sv
// Module: sticky match flag with read-to-clear and wakeup pulse.
// Assumes the strobe is one cycle wide; a set beats a same-cycle clear.
module cwd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic hit,
    input  logic wake_en,
    input  logic clr,
    output logic flag_q,
    output logic wake_q
);
    logic match;

    // A match needs both the strobe and an in-window value.
    always_comb begin
        match = strobe && hit;
    end

    // Sticky flag: set has priority over the read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (match) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    // One-cycle wakeup request per matching strobe when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= match && wake_en;
        end
    end
endmodule

// File: rtl/char_window_detect.sv
// Module: top of the received character window detector. Holds the
// bounds, compares each strobed character and reports flag and wakeup.
// Assumes the read data is consumed in the cycle the read strobe is high.
module char_window_detect
    import cwd_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                CHAR_W    = 8,
    parameter logic [ADDR_W-1:0] CMP_ADDR  = 12'h448,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h414
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wp_en,
    input  logic              wake_en,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              match_flag,
    output logic              wake_req
);
    win_cfg_t cfg_q;
    logic     hit;
    logic     stat_rd;

    cwd_cfg_reg #(.ADDR_W(ADDR_W), .CMP_ADDR(CMP_ADDR)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .wp_en (wp_en),
        .cfg_q (cfg_q)
    );

    cwd_window #(.CHAR_W(CHAR_W)) u_win (
        .char_in (rx_char),
        .cfg     (cfg_q),
        .hit     (hit)
    );

    // Decode a read of the status register for the clear.
    always_comb begin
        stat_rd = bus_rd && (bus_addr == STAT_ADDR);
    end

    cwd_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (rx_valid),
        .hit     (hit),
        .wake_en (wake_en),
        .clr     (stat_rd),
        .flag_q  (match_flag),
        .wake_q  (wake_req)
    );

    // Read mux: bounds or status bit, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == CMP_ADDR) begin
                bus_rdata = cfg_q;
            end else if (bus_addr == STAT_ADDR) begin
                bus_rdata = {31'b0, match_flag};
            end
        end
    end
endmodule

// File: rtl/cwd_chk.sv
// Module: property checker for the window detector, bound to the top.
// Assumes synchronous active-low reset; all properties idle in reset.
module cwd_chk
    import cwd_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CMP_ADDR  = 12'h448,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h414
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wp_en,
    input logic              wake_en,
    input logic              rx_valid,
    input logic              match_flag,
    input logic              wake_req,
    input win_cfg_t          cfg
);
    // R3
    wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wp_en && bus_addr == CMP_ADDR) |=> $stable(cfg));
    // R6
    no_strobe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(rx_valid));
    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == STAT_ADDR && !rx_valid) |=> !match_flag);
    // R8
    wake_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> match_flag);
    // R9
    empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(cfg.lo <= cfg.hi));
    // R10
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(rx_valid && wake_en));
endmodule

bind char_window_detect cwd_chk #(
    .ADDR_W(ADDR_W), .CMP_ADDR(CMP_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .wp_en      (wp_en),
    .wake_en    (wake_en),
    .rx_valid   (rx_valid),
    .match_flag (match_flag),
    .wake_req   (wake_req),
    .cfg        (cfg_q)
);

// File: tb/tb_char_window_detect.sv
// Bench: sweeps every 8-bit character through several windows, then
// runs directed cases for protection, strobe gating and read priority.
module tb_char_window_detect;
    localparam int ADDR_W = 12;
    localparam int CHAR_W = 8;
    localparam logic [ADDR_W-1:0] CMP  = 12'h448;
    localparam logic [ADDR_W-1:0] STAT = 12'h414;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              wp_en = 1'b0;
    logic              wake_en = 1'b0;
    logic              rx_valid = 1'b0;
    logic [CHAR_W-1:0] rx_char = '0;
    logic              match_flag;
    logic              wake_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    char_window_detect #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W),
                         .CMP_ADDR(CMP), .STAT_ADDR(STAT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wp_en(wp_en), .wake_en(wake_en), .rx_valid(rx_valid),
        .rx_char(rx_char), .match_flag(match_flag), .wake_req(wake_req)
    );

    task automatic check(input bit ok, input string req,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus write, driven at the falling edge, taken at the next rise.
    task automatic bwrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // One bus read; data sampled just before the rising edge.
    task automatic bread(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #5 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Program a window, then sweep all characters against it.
    task automatic sweep(input int lo, input int hi, input bit wk);
        logic [31:0] rd;
        bwrite(CMP, {hi[15:0], lo[15:0]});
        bread(CMP, rd);
        check(rd == {hi[15:0], lo[15:0]}, "R2", rd, {hi[15:0], lo[15:0]});
        bread(STAT, rd);
        wake_en = wk;
        for (int c = 0; c < 256; c++) begin
            bit exp = (c >= lo) && (c <= hi);
            @(negedge clk);
            rx_valid = 1'b1; rx_char = c[7:0];
            @(negedge clk);
            rx_valid = 1'b0;
            check(wake_req == (exp && wk), exp ? "R10" : "R9", wake_req, exp && wk);
            bread(STAT, rd);
            check(rd == {31'b0, exp}, (lo > hi) ? "R9" : "R5", rd, exp);
        end
        wake_en = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        check(match_flag == 1'b0 && wake_req == 1'b0, "R1",
              {match_flag, wake_req}, 0);
        rst_n = 1'b1;
        bread(CMP, rd);
        check(rd == 32'h0, "R1", rd, 0);

        sweep(16'h0040, 16'h0060, 1'b1);
        sweep(16'h0000, 16'h0000, 1'b0);
        sweep(16'h00FF, 16'h00FF, 1'b1);
        sweep(16'h0000, 16'hFFFF, 1'b0);
        sweep(16'h0060, 16'h0040, 1'b1);
        sweep(16'h0100, 16'h0200, 1'b1);

        // R3 / R4: protected write dropped, readback still works
        bwrite(CMP, 32'h0020_0010);
        wp_en = 1'b1;
        bwrite(CMP, 32'h1234_5678);
        bread(CMP, rd);
        check(rd == 32'h0020_0010, "R3", rd, 32'h0020_0010);
        check(rd[15:0] == 16'h0010, "R4", rd, 32'h0020_0010);
        wp_en = 1'b0;

        // R6: in-window value held without the strobe
        bread(STAT, rd);
        wake_en = 1'b1;
        @(negedge clk);
        rx_char = 8'h18;
        repeat (4) @(negedge clk);
        check(match_flag == 1'b0, "R6", match_flag, 0);
        check(wake_req == 1'b0, "R6", wake_req, 0);

        // R8: matching strobe during a status read keeps the flag
        @(negedge clk);
        rx_valid = 1'b1; bus_rd = 1'b1; bus_addr = STAT;
        #5 check(bus_rdata == 32'h0, "R7", bus_rdata, 0);
        @(negedge clk);
        rx_valid = 1'b0; bus_rd = 1'b0;
        check(match_flag == 1'b1, "R8", match_flag, 1);
        check(wake_req == 1'b1, "R10", wake_req, 1);
        @(negedge clk);
        check(wake_req == 1'b0, "R10", wake_req, 0);
        check(match_flag == 1'b1, "R7", match_flag, 1);
        bread(STAT, rd);
        check(rd == 32'h1, "R7", rd, 1);
        check(match_flag == 1'b0, "R7", match_flag, 0);
        wake_en = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule